// File: doc/BRIEF.md
# Peripheral Clock Gate Register Bank

This block holds the enable bits that switch a bank of peripheral clocks on and off. Software reaches it through a simple register port. Each 32-bit control word carries 16 gate enables in its lower half. The upper half of a written word is a per-bit change mask, so software can turn one clock on or off without a read-modify-write. To turn gate n of a register on, software writes `(1 << (n+16)) | (1 << n)`. To turn it off, it writes `1 << (n+16)`.

Every control register has a read-only companion at its own byte address plus 0x180. The companion reports whether each clock is really running. In this model a gate is a registered enable, and the running state is that enable delayed by a fixed settle time. Software polls the companion after enabling a gate. The settle time is a parameter, so the poll always completes within a known number of cycles.

The register at byte address 0x000 stands for clocks that have no gate. It reads as all enabled, its gates are held on, and writes to it do nothing. Register i sits at byte address 4*i, and byte-address bits 1:0 are ignored.

Top module: `cgb_bank`

## Requirements
- R1: When a control register is written, a low bit changes only if the flag in bit n+16 is set; then it takes the value of data bit n. Bits with a clear flag keep their value, and an idle port changes no enable.
- R2: Writing `(1<<(n+16))|(1<<n)` sets gate n of the addressed register; writing `1<<(n+16)` clears it; bit 16*i+n of `gate_en` carries gate n of register i.
- R3: A read of a control register returns its 16 enables in bits 15:0 and zero in bits 31:16.
- R4: A read at a control register's byte address plus 0x180 returns that register's running-clock state in bits 15:0 and zero in bits 31:16.
- R5: A running-clock bit takes the new enable value exactly SETTLE_CYC clock edges after the edge that changed the enable, and keeps its old value before that edge.
- R6: Register 0 (byte address 0x000) has no gate control: it reads 0x0000FFFF as control and as monitor, `gate_en[15:0]` are all 1, and writes to it change nothing.
- R7: After reset every gated register holds RST_EN (0x00A5 by default), and its monitor reads the same value.
- R8: A read of any address outside the control and monitor windows returns zero, and writes to monitor or unmapped addresses change no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data: change flags in 31:16, new values in 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gate_en | output | NUM_REGS*16 | Registered gate enables, register i in bits 16*i+15:16*i |

## Verification
Control readback and `gate_en` change at the rising edge that samples the write strobe. The bench therefore checks them at the falling edge right after that write. A monitor bit changes SETTLE_CYC edges after the enable changed. For every vector the bench reads the monitor at the falling edge after each of the first SETTLE_CYC-1 edges and expects the old value there; after edge SETTLE_CYC it expects the new one. Reads are combinational, so each read is sampled 1 ns after the address is driven on a falling edge.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
   localparam int unsigned GATES_PER_REG = 16;
   localparam int unsigned ADDR_W        = 12;
   localparam int unsigned DATA_W        = 32;
   localparam logic [ADDR_W-1:0] MON_BASE = 12'h180;

   typedef logic [GATES_PER_REG-1:0] gate_word_t;

   // Apply a masked write: flags in the upper half select the bits to replace.
   function automatic gate_word_t apply_masked(input gate_word_t cur,
                                               input logic [DATA_W-1:0] wd);
      gate_word_t flags;
      flags = wd[DATA_W-1:GATES_PER_REG];
      return (cur & ~flags) | (wd[GATES_PER_REG-1:0] & flags);
   endfunction

   // Word index of a byte address inside the control window.
   function automatic int unsigned ctrl_index(input logic [ADDR_W-1:0] a);
      return int'(a >> 2);
   endfunction

   // Word index of a byte address inside the monitor window.
   function automatic int unsigned mon_index(input logic [ADDR_W-1:0] a);
      return int'((a - MON_BASE) >> 2);
   endfunction
endpackage

// File: rtl/cgb_ctrl_reg.sv
module cgb_ctrl_reg
   import cgb_pkg::*;
#(
   parameter bit         UNGATED = 1'b0,
   parameter gate_word_t RST_EN  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output gate_word_t        en
);
   generate
      if (UNGATED) begin : g_fixed
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, wr_hit, wdata};
         assign en = '1;
      end else begin : g_gated
         gate_word_t en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      en_q <= RST_EN;
            else if (wr_hit) en_q <= apply_masked(en_q, wdata);
         end
         assign en = en_q;
      end
   endgenerate
endmodule

// File: rtl/cgb_settle_pipe.sv
module cgb_settle_pipe #(
   parameter int unsigned       WIDTH = 16,
   parameter int unsigned       DEPTH = 4,
   parameter logic [WIDTH-1:0]  RST_V = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [DEPTH];

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_V;
               else        stg[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_V;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/cgb_read_mux.sv
module cgb_read_mux
   import cgb_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [NUM_REGS*GATES_PER_REG-1:0] en_vec,
   input  logic [NUM_REGS*GATES_PER_REG-1:0] mon_vec,
   output logic [DATA_W-1:0]               rdata
);
   always_comb begin
      rdata = '0;
      if (addr < MON_BASE) begin
         if (ctrl_index(addr) < NUM_REGS)
            rdata[GATES_PER_REG-1:0] = en_vec[ctrl_index(addr)*GATES_PER_REG +: GATES_PER_REG];
      end else begin
         if (mon_index(addr) < NUM_REGS)
            rdata[GATES_PER_REG-1:0] = mon_vec[mon_index(addr)*GATES_PER_REG +: GATES_PER_REG];
      end
   end
endmodule

// File: rtl/cgb_bank.sv
module cgb_bank
   import cgb_pkg::*;
#(
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned SETTLE_CYC = 4,
   parameter logic [15:0] RST_EN     = 16'h00A5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_wr,
   input  logic [11:0]                   bus_addr,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   output logic [NUM_REGS*16-1:0]        gate_en
);
   localparam int unsigned NUM_GATES = NUM_REGS * GATES_PER_REG;
   localparam logic [NUM_GATES-1:0] RST_VEC =
      {{(NUM_REGS-1){RST_EN}}, {GATES_PER_REG{1'b1}}};

   generate
      if (NUM_REGS < 2 || NUM_REGS * 4 > int'(MON_BASE)) begin : g_bad_regs
         $error("cgb_bank: NUM_REGS must be 2..96");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("cgb_bank: SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic [NUM_GATES-1:0] mon_vec;
   logic                 in_ctrl;

   assign in_ctrl = (bus_addr < MON_BASE);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic wr_hit;
         assign wr_hit = bus_wr && in_ctrl && (ctrl_index(bus_addr) == i);
         cgb_ctrl_reg #(
            .UNGATED (i == 0),
            .RST_EN  (RST_EN)
         ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_hit),
            .wdata  (bus_wdata),
            .en     (gate_en[i*GATES_PER_REG +: GATES_PER_REG])
         );
      end
   endgenerate

   cgb_settle_pipe #(
      .WIDTH (NUM_GATES),
      .DEPTH (SETTLE_CYC),
      .RST_V (RST_VEC)
   ) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gate_en),
      .q     (mon_vec)
   );

   cgb_read_mux #(
      .NUM_REGS (NUM_REGS)
   ) u_rmux (
      .addr    (bus_addr),
      .en_vec  (gate_en),
      .mon_vec (mon_vec),
      .rdata   (bus_rdata)
   );
endmodule

// File: rtl/cgb_bank_chk.sv
module cgb_bank_chk
   import cgb_pkg::*;
#(
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned SETTLE_CYC = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic [11:0]            bus_addr,
   input logic [31:0]            bus_rdata,
   input logic [NUM_REGS*16-1:0] gate_en,
   input logic [NUM_REGS*16-1:0] mon_vec
);
   localparam int unsigned CW = $clog2(SETTLE_CYC + 1) + 1;

   logic [NUM_REGS*16-1:0] gate_prev;
   logic [CW-1:0]          quiet_cnt;
   logic                   unmapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_prev <= '0;
         quiet_cnt <= CW'(SETTLE_CYC);
      end else begin
         gate_prev <= gate_en;
         if (gate_en != gate_prev && quiet_cnt != CW'(SETTLE_CYC) + CW'(1))
            quiet_cnt <= '0;
         else if (gate_en != gate_prev)
            quiet_cnt <= '0;
         else if (quiet_cnt < CW'(SETTLE_CYC))
            quiet_cnt <= quiet_cnt + CW'(1);
      end
   end

   assign unmapped = (bus_addr < MON_BASE) ? ((bus_addr >> 2) >= NUM_REGS)
                                           : (((bus_addr - MON_BASE) >> 2) >= NUM_REGS);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(gate_en)) else $error("idle port changed enables"); // R1

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:16] == 16'h0) else $error("upper half not zero"); // R3

   AST_MON_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt >= CW'(SETTLE_CYC - 1) && gate_en == gate_prev) |-> (mon_vec == gate_en))
      else $error("monitor not settled"); // R5

   AST_UNGATED_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr >> 2) == 12'h0) |=> $stable(gate_en))
      else $error("write to ungated register had effect"); // R6

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (bus_rdata == 32'h0)) else $error("unmapped read not zero"); // R8
endmodule

bind cgb_bank cgb_bank_chk #(
   .NUM_REGS   (NUM_REGS),
   .SETTLE_CYC (SETTLE_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .gate_en   (gate_en),
   .mon_vec   (mon_vec)
);

// File: tb/tb_cgb_bank.sv
`timescale 1ns/1ps
module tb_cgb_bank;
   localparam int NR     = 4;
   localparam int SETTLE = 4;
   localparam logic [15:0] RSTV = 16'h00A5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NR*16-1:0] gate_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cgb_bank #(.NUM_REGS(NR), .SETTLE_CYC(SETTLE), .RST_EN(RSTV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_en(gate_en));

   // {address, write data, expected control value afterwards}
   localparam int NV = 8;
   localparam logic [75:0] VEC [NV] = '{
      {12'h004, 32'h0002_0002, 32'h0000_00A7},  // R2 on
      {12'h004, 32'h0001_0000, 32'h0000_00A6},  // R2 off
      {12'h004, 32'h0000_FFFF, 32'h0000_00A6},  // R1 no flags
      {12'h004, 32'hFFFF_1234, 32'h0000_1234},  // R1 all flags
      {12'h008, 32'hFF00_AB00, 32'h0000_ABA5},  // R1 upper byte
      {12'h00C, 32'h00F0_0F0F, 32'h0000_0005},  // R1 partial
      {12'h008, 32'h8000_0000, 32'h0000_2BA5},  // R2 off bit15
      {12'h00C, 32'h8000_8000, 32'h0000_8005}   // R2 on bit15
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      logic [15:0] model [NR];
      logic [NR*16-1:0] snap;
      model[0] = 16'hFFFF;
      for (int i = 1; i < NR; i++) model[i] = RSTV;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      for (int i = 0; i < NR; i++) begin
         rd(12'(4*i), r);
         chk(i == 0 ? "R6 ctrl read" : "R7 reset ctrl", 64'(r), 64'({16'h0, model[i]}));
         rd(12'h180 + 12'(4*i), r);
         chk(i == 0 ? "R6 mon read" : "R7 reset mon", 64'(r), 64'({16'h0, model[i]}));
      end
      chk("R7 reset gate_en", 64'(gate_en), 64'({RSTV, RSTV, RSTV, 16'hFFFF}));

      // Vector table
      for (int v = 0; v < NV; v++) begin
         logic [11:0] a;
         logic [31:0] d, e;
         int ri;
         logic [15:0] old;
         {a, d, e} = VEC[v];
         ri = int'(a >> 2);
         old = model[ri];
         wr(a, d);
         model[ri] = e[15:0];
         rd(a, r);
         chk("R1 R3 ctrl readback", 64'(r), 64'(e));
         chk("R2 gate_en slice", 64'(gate_en[ri*16 +: 16]), 64'(e[15:0]));
         rd(12'h180 + a, r);
         chk("R5 mon before settle", 64'(r), 64'({16'h0, old}));
         for (int k = 1; k < SETTLE; k++) begin
            @(negedge clk);
            rd(12'h180 + a, r);
            chk("R5 mon still old", 64'(r), 64'({16'h0, old}));
         end
         @(negedge clk);
         rd(12'h180 + a, r);
         chk("R4 R5 mon settled", 64'(r), 64'(e));
      end

      // Ungated register ignores writes
      snap = gate_en;
      wr(12'h000, 32'hFFFF_0000);
      rd(12'h000, r);
      chk("R6 ctrl after write", 64'(r), 64'h0000_FFFF);
      chk("R6 gate_en unchanged", 64'(gate_en), 64'(snap));
      repeat (SETTLE) @(negedge clk);
      rd(12'h180, r);
      chk("R6 mon after write", 64'(r), 64'h0000_FFFF);

      // Monitor and unmapped writes ignored
      wr(12'h184, 32'hFFFF_0000);
      chk("R8 mon write ignored", 64'(gate_en), 64'(snap));
      wr(12'h040, 32'hFFFF_0000);
      chk("R8 unmapped write ignored", 64'(gate_en), 64'(snap));
      rd(12'h004, r);
      chk("R8 reg1 intact", 64'(r), 64'({16'h0, model[1]}));

      // Unmapped reads
      rd(12'h010, r);
      chk("R8 unmapped ctrl read", 64'(r), 64'h0);
      rd(12'h190, r);
      chk("R8 unmapped mon read", 64'(r), 64'h0);
      rd(12'hFFC, r);
      chk("R8 top address read", 64'(r), 64'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule